// File: doc/BRIEF.md
# Bank Busy Tracker

This block keeps track of which banks of a multi-bank storage array are occupied. A cache controller uses it to decide whether an access to a given set index may issue in the current cycle. Each index belongs to one bank. A booking holds that bank for a fixed number of cycles, and a clash between bookings is latched as an error.

The query side is combinational. It takes an index and reports whether that index's bank is free in the present cycle. The reservation side has several ports, and each port books the bank of its index at the next clock edge. Within one cycle the ports are judged in order of port number, so a lower-numbered port claims a free bank first. A later port that names the same bank with the same index joins that booking, which covers a read and a write to one entry. A later port that names the same bank with a different index is a clash. Any reservation to a bank that is still held by an earlier cycle is also a clash. A clash sets a sticky error flag and leaves the existing booking unchanged.

The bank count must be a power of two. The access latency may be zero, which disables tracking.

Top module: `bank_busy_tracker`

## Requirements
- R1: After reset every bank is free and `err_sticky` is 0.
- R2: The bank of an index is the index modulo `NUM_BANKS`, which is its low log2(`NUM_BANKS`) bits. Two indices with equal low bits share a bank. With one bank, all indices share bank 0.
- R3: A reservation accepted in cycle T makes `qry_free` read 0 for every index of that bank in cycles T+1 to T+`LATENCY`-1. From cycle T+`LATENCY` on, `qry_free` reads 1 and a new reservation to that bank is accepted without error.
- R4: A query in the same cycle as a reservation to its bank sees the state from before that reservation.
- R5: A reservation has no effect on `qry_free` for indices of other banks.
- R6: Two ports that reserve the same index in the same cycle, with its bank free, produce one booking and no error.
- R7: A reservation to a bank held from an earlier cycle, whether with the same index or another one, sets `err_sticky` at the next edge. The existing booking keeps its original end cycle.
- R8: When two ports reserve different indices of one free bank in the same cycle, the lower-numbered port (port p uses bits [p*IDX_W +: IDX_W] of `rsv_idx`) gets the booking and `err_sticky` is set.
- R9: Once set, `err_sticky` stays 1 until reset.
- R10: With `LATENCY` = 0, `qry_free` is always 1, reservations book nothing, and `err_sticky` never sets.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| qry_idx | input | IDX_W | Index whose bank is queried |
| qry_free | output | 1 | 1 when the queried bank is free in this cycle |
| rsv_vld | input | RSV_PORTS | One valid bit per reservation port |
| rsv_idx | input | RSV_PORTS*IDX_W | Reservation indices, port p in bits [p*IDX_W +: IDX_W] |
| err_sticky | output | 1 | Latched reservation clash flag |

## Verification
A query and a reservation can fall in the same cycle, and so can reservations on the two ports. The bench drives both combinations on purpose. It sweeps every reservation index against every query index from the reservation cycle through the end of the window. It drives both ports at once with equal indices, with different indices in one bank, and with different banks, and it books again into a bank while it is still held. A cycle-stamped reference model applies the ports in port order and decides the result. It records a start and an end cycle for each bank. The query is judged against the model state from before the current cycle's reservations.

// File: rtl/bt_pkg.sv
package bt_pkg;
  // Outcome of one reservation port in one cycle.
  typedef enum logic [1:0] {
    RSV_NONE  = 2'd0,
    RSV_TAKE  = 2'd1,
    RSV_SHARE = 2'd2,
    RSV_CLASH = 2'd3
  } rsv_res_e;
endpackage

// File: rtl/bt_bank_sel.sv
module bt_bank_sel #(
  parameter int IDX_W     = 8,
  parameter int NUM_BANKS = 4,
  parameter int BANK_W    = 2
) (
  input  logic [IDX_W-1:0]  idx,
  output logic [BANK_W-1:0] bank
);
  // NUM_BANKS is a power of two, so this reduces to a slice of low bits;
  // with a single bank the remainder is always zero.
  always_comb bank = BANK_W'(idx % IDX_W'(NUM_BANKS));
endmodule

// File: rtl/bt_bank_slot.sv
module bt_bank_slot #(
  parameter int LATENCY = 3,
  parameter int CNT_W   = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  output logic busy
);
  localparam logic [CNT_W-1:0] RELOAD = CNT_W'((LATENCY > 0) ? LATENCY - 1 : 0);

  logic [CNT_W-1:0] rem_q;
  logic [CNT_W-1:0] rem_d;
  logic             rem_en;

  // Remaining busy cycles after the current one.
  always_comb begin
    rem_en = load | (rem_q != '0);
    rem_d  = load ? RELOAD : (rem_q - 1'b1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q <= '0;
    end else if (rem_en) begin
      rem_q <= rem_d;
    end
  end

  assign busy = (rem_q != '0);
endmodule

// File: rtl/bt_rsv_resolve.sv
module bt_rsv_resolve
  import bt_pkg::*;
#(
  parameter int IDX_W     = 8,
  parameter int NUM_BANKS = 4,
  parameter int BANK_W    = 2,
  parameter int RSV_PORTS = 2,
  parameter bit LAT_ON    = 1'b1
) (
  input  logic [NUM_BANKS-1:0]       bank_busy,
  input  logic [RSV_PORTS-1:0]       rsv_vld,
  input  logic [RSV_PORTS*IDX_W-1:0] rsv_idx,
  output logic [NUM_BANKS-1:0]       bank_load,
  output logic                       clash
);
  logic [IDX_W-1:0]  port_idx  [RSV_PORTS];
  logic [BANK_W-1:0] port_bank [RSV_PORTS];
  rsv_res_e          port_res  [RSV_PORTS];

  for (genvar p = 0; p < RSV_PORTS; p++) begin : g_port
    assign port_idx[p] = rsv_idx[p*IDX_W +: IDX_W];
    bt_bank_sel #(
      .IDX_W    (IDX_W),
      .NUM_BANKS(NUM_BANKS),
      .BANK_W   (BANK_W)
    ) u_sel (
      .idx (port_idx[p]),
      .bank(port_bank[p])
    );
  end

  // Ports are judged in ascending order; each sees the claims of the
  // lower-numbered ports made in this same cycle.
  always_comb begin : resolve
    logic [NUM_BANKS-1:0] taken;
    logic [IDX_W-1:0]     owner [NUM_BANKS];
    taken = '0;
    for (int b = 0; b < NUM_BANKS; b++) owner[b] = '0;
    for (int p = 0; p < RSV_PORTS; p++) begin
      port_res[p] = RSV_NONE;
      if (LAT_ON && rsv_vld[p]) begin
        if (bank_busy[port_bank[p]]) begin
          port_res[p] = RSV_CLASH;
        end else if (taken[port_bank[p]]) begin
          port_res[p] = (owner[port_bank[p]] == port_idx[p]) ? RSV_SHARE : RSV_CLASH;
        end else begin
          port_res[p]             = RSV_TAKE;
          taken[port_bank[p]]     = 1'b1;
          owner[port_bank[p]]     = port_idx[p];
        end
      end
    end
    bank_load = taken;
  end

  always_comb begin
    clash = 1'b0;
    for (int p = 0; p < RSV_PORTS; p++) begin
      if (port_res[p] == RSV_CLASH) clash = 1'b1;
    end
  end
endmodule

// File: rtl/bank_busy_tracker.sv
module bank_busy_tracker #(
  parameter int NUM_BANKS = 4,
  parameter int LATENCY   = 3,
  parameter int IDX_W     = 8,
  parameter int RSV_PORTS = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [IDX_W-1:0]           qry_idx,
  output logic                       qry_free,
  input  logic [RSV_PORTS-1:0]       rsv_vld,
  input  logic [RSV_PORTS*IDX_W-1:0] rsv_idx,
  output logic                       err_sticky
);
  localparam int BANK_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1;
  localparam int CNT_W  = (LATENCY > 1) ? $clog2(LATENCY) : 1;
  localparam bit LAT_ON = (LATENCY > 0);

  // Reset: asserted asynchronously, released after two clean edges.
  logic [1:0] rst_pipe_q;
  logic       srst_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe_q <= '0;
    end else begin
      rst_pipe_q <= {rst_pipe_q[0], 1'b1};
    end
  end
  assign srst_n = rst_pipe_q[1];

  logic [NUM_BANKS-1:0] bank_busy;
  logic [NUM_BANKS-1:0] bank_load;
  logic                 clash;

  bt_rsv_resolve #(
    .IDX_W    (IDX_W),
    .NUM_BANKS(NUM_BANKS),
    .BANK_W   (BANK_W),
    .RSV_PORTS(RSV_PORTS),
    .LAT_ON   (LAT_ON)
  ) u_resolve (
    .bank_busy(bank_busy),
    .rsv_vld  (rsv_vld),
    .rsv_idx  (rsv_idx),
    .bank_load(bank_load),
    .clash    (clash)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    bt_bank_slot #(
      .LATENCY(LATENCY),
      .CNT_W  (CNT_W)
    ) u_slot (
      .clk  (clk),
      .rst_n(srst_n),
      .load (bank_load[b]),
      .busy (bank_busy[b])
    );
  end

  // Query path: combinational, reflects registered state only.
  logic [BANK_W-1:0] qry_bank;

  bt_bank_sel #(
    .IDX_W    (IDX_W),
    .NUM_BANKS(NUM_BANKS),
    .BANK_W   (BANK_W)
  ) u_qsel (
    .idx (qry_idx),
    .bank(qry_bank)
  );

  assign qry_free = ~(LAT_ON & bank_busy[qry_bank]);

  // Sticky clash flag.
  logic err_q;
  logic err_d;
  logic err_en;

  always_comb begin
    err_en = clash;
    err_d  = 1'b1;
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      err_q <= 1'b0;
    end else if (err_en) begin
      err_q <= err_d;
    end
  end

  assign err_sticky = err_q;
endmodule

// File: rtl/bt_tracker_chk.sv
module bt_tracker_chk #(
  parameter int NUM_BANKS = 4,
  parameter int LATENCY   = 3,
  parameter int IDX_W     = 8,
  parameter int RSV_PORTS = 2
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       qry_free,
  input logic [RSV_PORTS-1:0]       rsv_vld,
  input logic [RSV_PORTS*IDX_W-1:0] rsv_idx,
  input logic                       err_sticky,
  input logic [NUM_BANKS-1:0]       bank_busy
);
  logic [NUM_BANKS-1:0] hit_any;
  logic [NUM_BANKS-1:0] hit_p0;

  always_comb begin
    hit_any = '0;
    hit_p0  = '0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      for (int p = 0; p < RSV_PORTS; p++) begin
        if (rsv_vld[p] &&
            ((rsv_idx[p*IDX_W +: IDX_W] % IDX_W'(NUM_BANKS)) == IDX_W'(b))) begin
          hit_any[b] = 1'b1;
          if (p == 0) hit_p0[b] = 1'b1;
        end
      end
    end
  end

  assert_err_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    err_sticky |=> err_sticky);

  assert_err_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_sticky) |-> $past(|rsv_vld));

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank_chk
    assert_busy_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(bank_busy[b]) |-> $past(hit_any[b]));

    if (LATENCY >= 2) begin : g_take
      // Port 0 always wins a free bank (R8 ordering).
      assert_port0_take_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_p0[b] && !bank_busy[b]) |=> bank_busy[b]);
    end
  end

  if (LATENCY == 0) begin : g_lat0
    assert_lat0_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
      qry_free && !err_sticky);
  end
endmodule

bind bank_busy_tracker bt_tracker_chk #(
  .NUM_BANKS(NUM_BANKS),
  .LATENCY  (LATENCY),
  .IDX_W    (IDX_W),
  .RSV_PORTS(RSV_PORTS)
) u_chk (
  .clk       (clk),
  .rst_n     (srst_n),
  .qry_free  (qry_free),
  .rsv_vld   (rsv_vld),
  .rsv_idx   (rsv_idx),
  .err_sticky(err_sticky),
  .bank_busy (bank_busy)
);

// File: tb/tb_bank_busy_tracker.sv
`timescale 1ns/1ps
module tb_bank_busy_tracker;
  localparam int NB  = 4;
  localparam int LAT = 3;
  localparam int IW  = 4;
  localparam int NP  = 2;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [IW-1:0]    qry_idx = '0;
  logic [NP-1:0]    rsv_vld = '0;
  logic [NP*IW-1:0] rsv_idx = '0;
  logic free_m, err_m, free_one, err_one, free_z, err_z;

  always #2.5 clk = ~clk;

  bank_busy_tracker #(.NUM_BANKS(NB), .LATENCY(LAT), .IDX_W(IW), .RSV_PORTS(NP)) dut (
    .clk(clk), .rst_n(rst_n), .qry_idx(qry_idx), .qry_free(free_m),
    .rsv_vld(rsv_vld), .rsv_idx(rsv_idx), .err_sticky(err_m));

  bank_busy_tracker #(.NUM_BANKS(1), .LATENCY(2), .IDX_W(IW), .RSV_PORTS(NP)) dut_one (
    .clk(clk), .rst_n(rst_n), .qry_idx(qry_idx), .qry_free(free_one),
    .rsv_vld(rsv_vld), .rsv_idx(rsv_idx), .err_sticky(err_one));

  bank_busy_tracker #(.NUM_BANKS(NB), .LATENCY(0), .IDX_W(IW), .RSV_PORTS(NP)) dut_lat0 (
    .clk(clk), .rst_n(rst_n), .qry_idx(qry_idx), .qry_free(free_z),
    .rsv_vld(rsv_vld), .rsv_idx(rsv_idx), .err_sticky(err_z));

  int n_chk = 0;
  int n_err = 0;
  bit done  = 1'b0;

  // Reference model: cycle-stamped windows, ports applied in order.
  int cyc = 0;
  int m_start [NB];
  int m_end   [NB];
  int m_own   [NB];
  bit m_err;

  task automatic chk(input logic act, input logic exp, input string tag, input string what);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual %0b expected %0b (cycle %0d)", tag, what, act, exp, cyc);
    end
  endtask

  task automatic model_reset();
    for (int b = 0; b < NB; b++) begin
      m_start[b] = -1000;
      m_end[b]   = -1000;
      m_own[b]   = -1;
    end
    m_err = 1'b0;
  endtask

  task automatic model_rsv(input int idx);
    int b;
    b = idx % NB;
    if (cyc <= m_end[b]) begin
      if (!(m_start[b] == cyc && m_own[b] == idx)) m_err = 1'b1;
    end else begin
      m_start[b] = cyc;
      m_end[b]   = cyc + LAT - 1;
      m_own[b]   = idx;
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n   = 1'b0;
    rsv_vld = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
    model_reset();
  endtask

  // One cycle: drive at the falling edge, check before the rising edge.
  task automatic step(input bit v0, input int i0, input bit v1, input int i1,
                      input int q, input string tag);
    @(negedge clk);
    rsv_vld = {v1, v0};
    rsv_idx = {IW'(i1), IW'(i0)};
    qry_idx = IW'(q);
    #1;
    chk(free_m, !(cyc <= m_end[q % NB]), tag, "qry_free");
    chk(err_m, m_err, m_err ? "R9" : "R7", "err_sticky");
    chk(free_z, 1'b1, "R10", "qry_free lat0");
    chk(err_z, 1'b0, "R10", "err_sticky lat0");
    if (v0) model_rsv(i0);
    if (v1) model_rsv(i1);
    cyc++;
  endtask

  task automatic idle(input int n, input int q, input string tag);
    for (int k = 0; k < n; k++) step(0, 0, 0, 0, q, tag);
  endtask

  initial begin
    model_reset();
    do_reset();

    // R1: reset state over every index
    for (int q = 0; q < (1 << IW); q++) step(0, 0, 0, 0, q, "R1");
    chk(err_m, 1'b0, "R1", "err after reset");

    // R2 R3 R4 R5 sweep: every reservation index against every query index
    for (int r = 0; r < (1 << IW); r++) begin
      for (int q = 0; q < (1 << IW); q++) begin
        string t;
        t = ((q % NB) != (r % NB)) ? "R5" : ((q == r) ? "R3" : "R2");
        step(1, r, 0, 0, q, "R4");
        idle(LAT, q, t);
      end
    end

    // R3: rebook exactly when the window ends
    step(1, 1, 0, 0, 1, "R3");
    idle(LAT - 1, 1, "R3");
    step(1, 9, 0, 0, 1, "R3");
    idle(LAT, 9, "R3");
    chk(err_m, 1'b0, "R3", "rebook at window end");

    // R6: same index on both ports in one cycle
    step(1, 5, 1, 5, 5, "R6");
    idle(LAT, 5, "R6");
    chk(err_m, 1'b0, "R6", "shared booking error");

    // two different banks in one cycle: both taken, no error
    step(1, 2, 1, 7, 7, "R5");
    idle(LAT, 7, "R5");
    chk(err_m, 1'b0, "R5", "two banks error");

    // R7: same index again one cycle later, booking end unchanged
    step(1, 3, 0, 0, 3, "R7");
    step(0, 0, 1, 3, 3, "R7");
    step(0, 0, 0, 0, 3, "R7");
    chk(err_m, 1'b1, "R7", "err after rebook of held bank");
    step(0, 0, 0, 0, 3, "R7");
    chk(free_m, 1'b1, "R7", "original window kept");
    idle(20, 0, "R9");
    chk(err_m, 1'b1, "R9", "err still set");
    do_reset();
    chk(err_m, 1'b0, "R1", "err cleared by reset");

    // R8: different indices, same bank, same cycle; port 0 owns
    step(1, 2, 1, 6, 6, "R8");
    step(0, 0, 0, 0, 6, "R8");
    chk(err_m, 1'b1, "R8", "same-cycle clash");
    idle(LAT - 1, 10, "R8");
    do_reset();

    // R2 with one bank: all indices share bank 0 (latency 2)
    step(1, 5, 0, 0, 10, "R4");
    chk(free_one, 1'b1, "R4", "one-bank pre-state");
    step(0, 0, 0, 0, 10, "R2");
    chk(free_one, 1'b0, "R2", "one-bank shared busy");
    step(0, 0, 0, 0, 10, "R2");
    chk(free_one, 1'b1, "R2", "one-bank window end");
    step(1, 3, 1, 12, 0, "R2");
    step(0, 0, 0, 0, 0, "R2");
    chk(err_one, 1'b1, "R2", "one-bank clash");
    chk(err_m, 1'b0, "R5", "different banks on four-bank array");
    do_reset();

    // mixed traffic against the model
    begin
      logic [15:0] lf;
      lf = 16'hACE1;
      for (int n = 0; n < 3000; n++) begin
        lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
        step(lf[0] & lf[1], int'(lf[7:4]), lf[2] & lf[3], int'(lf[11:8]),
             int'(lf[15:12]), "R3");
        if (n % 300 == 299) do_reset();
      end
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog: actual running expected done");
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end
endmodule